// File: doc/BRIEF.md
# Programmable Parallel Port Controller

This block gives a processor twenty-four general-purpose I/O lines, grouped as three 8-bit ports (A, B and C). Port C is split into an upper and a lower nibble whose directions are set independently. The processor reaches the block over a small 8-bit register interface with chip select, read and write strobes and a two-bit register address. Three addresses reach the port data registers and the fourth reaches a write-only control register.

A control byte does one of two things. A configuration word sets the direction of each port group and returns every output latch to zero. A bit-command word forces one chosen bit of port C high or low without disturbing the others, so no read-modify-write is needed. Only basic input/output behaviour is implemented. The group-mode fields of a configuration word are accepted and stored, but they do not change how any port behaves.

Each pin group has an output-enable for a tri-state pad. Reads are answered combinationally. An output port reads back its latch, and an input port reads the live pins.

Top module: `pio_port_ctrl`

## Requirements
- R1: After a synchronous reset every output-enable (`pa_oe`, `pb_oe`, `pc_oe_hi`, `pc_oe_lo`) is low and every output latch (`pa_out`, `pb_out`, `pc_out`) is 0x00.
- R2: When `cs` and `wr` are both high at a rising clock edge with `addr` 00, 01 or 10, the value on `wdata` is stored in the latch of port A, B or C respectively and appears on that port's output from the next cycle on, whatever the port's direction.
- R3: A write strobe with `cs` low changes no latch and no direction.
- R4: A write to `addr` 11 with `wdata[7]`=1 is a configuration word: bit 4 sets port A, bit 3 the port C upper nibble, bit 1 port B and bit 0 the port C lower nibble, where 1 means input (output-enable low) and 0 means output (output-enable high).
- R5: A configuration word clears all three output latches to 0x00.
- R6: A write to `addr` 11 with `wdata[7]`=0 is a bit command: bits 3:1 give the index of the port C bit and bit 0 gives its new value. All other port C bits and all directions stay unchanged.
- R7: While `cs` and `rd` are high, reading a port returns its live pins if the port is an input and its latch if it is an output. Port C is resolved nibble by nibble according to each nibble's own direction.
- R8: Reading `addr` 11 returns 0x00, and `rdata` is 0x00 whenever `cs` and `rd` are not both high.
- R9: The mode fields of a configuration word (bits 6:5 and bit 2) have no effect: a word that requests strobed or bidirectional modes behaves exactly like basic mode with the same direction bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cs | input | 1 | Chip select, active high |
| rd | input | 1 | Read strobe, active high |
| wr | input | 1 | Write strobe, active high |
| addr | input | 2 | Register address: 00 A, 01 B, 10 C, 11 control |
| wdata | input | 8 | Write data from the processor |
| rdata | output | 8 | Read data to the processor |
| pa_in | input | 8 | Port A pin values |
| pa_out | output | 8 | Port A output latch |
| pa_oe | output | 1 | Port A output-enable |
| pb_in | input | 8 | Port B pin values |
| pb_out | output | 8 | Port B output latch |
| pb_oe | output | 1 | Port B output-enable |
| pc_in | input | 8 | Port C pin values |
| pc_out | output | 8 | Port C output latch |
| pc_oe_hi | output | 1 | Port C bits 7:4 output-enable |
| pc_oe_lo | output | 1 | Port C bits 3:0 output-enable |

## Verification
The bench covers the following corner cases:

- **Bit commands.** A bit command hits the lowest and highest port C bits and clears a bit that is already low. A design that decodes the index wrongly, or that rewrites the whole nibble, alters neighbouring bits.
- **Mixed-direction port C.** Port C is read with one nibble as input and the other as output. A design that resolves direction per port rather than per nibble returns latch bits where pins belong.
- **Configuration words.** A configuration word is written while the latches hold non-zero data. A design that forgets the clear keeps driving stale values.
- **Mode bits set.** A word that sets all mode bits must still give the same directions as basic mode.
- **Gated accesses.** Writes with chip select low, and reads with the strobe low, must leave state and the read bus untouched. A design that ignores the select corrupts latches or drives `rdata` when it should not.

// File: rtl/ppc_pkg.sv
package ppc_pkg;

    localparam int PORT_W   = 8;
    localparam int HALF_W   = PORT_W / 2;
    localparam int N_PORTS  = 3;
    localparam int IDX_W    = $clog2(PORT_W);

    typedef enum logic [1:0] {
        SEL_A    = 2'b00,
        SEL_B    = 2'b01,
        SEL_C    = 2'b10,
        SEL_CTRL = 2'b11
    } reg_sel_e;

    typedef struct packed {
        logic [1:0] grp_a_mode;
        logic       grp_b_mode;
        logic       a_is_in;
        logic       cu_is_in;
        logic       b_is_in;
        logic       cl_is_in;
    } port_cfg_t;

    typedef struct packed {
        logic [N_PORTS-1:0] wr_port;
        logic               wr_cfg;
        logic               wr_bit;
        logic               rd_en;
        reg_sel_e           sel;
    } bus_dec_t;

    localparam port_cfg_t CFG_RESET = '{
        grp_a_mode: 2'b00, grp_b_mode: 1'b0,
        a_is_in: 1'b1, cu_is_in: 1'b1, b_is_in: 1'b1, cl_is_in: 1'b1
    };

    function automatic port_cfg_t decode_cfg(input logic [PORT_W-1:0] w);
        port_cfg_t c;
        c.grp_a_mode = w[6:5];
        c.grp_b_mode = w[2];
        c.a_is_in    = w[4];
        c.cu_is_in   = w[3];
        c.b_is_in    = w[1];
        c.cl_is_in   = w[0];
        return c;
    endfunction

    function automatic logic [PORT_W-1:0] port_view(
        input logic [PORT_W-1:0] latch,
        input logic [PORT_W-1:0] pins,
        input logic              is_in
    );
        return is_in ? pins : latch;
    endfunction

endpackage

// File: rtl/ppc_bus_decode.sv
module ppc_bus_decode
    import ppc_pkg::*;
(
    input  logic              cs,
    input  logic              rd,
    input  logic              wr,
    input  logic [1:0]        addr,
    input  logic [PORT_W-1:0] wdata,
    output bus_dec_t          dec
);
    logic wr_any;

    always_comb begin
        wr_any     = cs & wr;
        dec.sel    = reg_sel_e'(addr);
        dec.rd_en  = cs & rd;
        for (int i = 0; i < N_PORTS; i++) begin
            dec.wr_port[i] = wr_any && (addr == 2'(i));
        end
        dec.wr_cfg = wr_any && (dec.sel == SEL_CTRL) &&  wdata[PORT_W-1];
        dec.wr_bit = wr_any && (dec.sel == SEL_CTRL) && !wdata[PORT_W-1];
    end
endmodule

// File: rtl/ppc_out_latch.sv
module ppc_out_latch #(
    parameter int W  = 8,
    parameter int IW = $clog2(W)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          load,
    input  logic [W-1:0]  load_val,
    input  logic          bit_we,
    input  logic [IW-1:0] bit_idx,
    input  logic          bit_val,
    output logic [W-1:0]  q
);
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            q <= '0;
        end else if (load) begin
            q <= load_val;
        end else if (bit_we) begin
            q[bit_idx] <= bit_val;
        end
    end

    // R6: a single-bit command leaves every other bit of the latch alone
    p_bit_only_r6: assert property (@(posedge clk) disable iff (rst)
        (bit_we && !clr && !load) |=>
            (((q ^ $past(q)) & ~(W'(1) << $past(bit_idx))) == '0))
        else $error("bit command disturbed neighbouring bits");
endmodule

// File: rtl/ppc_cfg_reg.sv
module ppc_cfg_reg
    import ppc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_cfg,
    input  logic [PORT_W-1:0] wdata,
    output port_cfg_t         cfg
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= CFG_RESET;
        end else if (wr_cfg) begin
            cfg <= decode_cfg(wdata);
        end
    end
endmodule

// File: rtl/ppc_rd_mux.sv
module ppc_rd_mux
    import ppc_pkg::*;
(
    input  bus_dec_t                        dec,
    input  port_cfg_t                       cfg,
    input  logic [N_PORTS-1:0][PORT_W-1:0]  lat,
    input  logic [PORT_W-1:0]               pa_in,
    input  logic [PORT_W-1:0]               pb_in,
    input  logic [PORT_W-1:0]               pc_in,
    output logic [PORT_W-1:0]               rdata
);
    logic [PORT_W-1:0] c_hi_view;
    logic [PORT_W-1:0] c_lo_view;

    always_comb begin
        c_hi_view = port_view(lat[2], pc_in, cfg.cu_is_in);
        c_lo_view = port_view(lat[2], pc_in, cfg.cl_is_in);
        rdata     = '0;
        if (dec.rd_en) begin
            unique case (dec.sel)
                SEL_A:    rdata = port_view(lat[0], pa_in, cfg.a_is_in);
                SEL_B:    rdata = port_view(lat[1], pb_in, cfg.b_is_in);
                SEL_C:    rdata = {c_hi_view[PORT_W-1:HALF_W], c_lo_view[HALF_W-1:0]};
                SEL_CTRL: rdata = '0;
                default:  rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/pio_port_ctrl.sv
module pio_port_ctrl
    import ppc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cs,
    input  logic        rd,
    input  logic        wr,
    input  logic [1:0]  addr,
    input  logic [7:0]  wdata,
    output logic [7:0]  rdata,
    input  logic [7:0]  pa_in,
    output logic [7:0]  pa_out,
    output logic        pa_oe,
    input  logic [7:0]  pb_in,
    output logic [7:0]  pb_out,
    output logic        pb_oe,
    input  logic [7:0]  pc_in,
    output logic [7:0]  pc_out,
    output logic        pc_oe_hi,
    output logic        pc_oe_lo
);
    bus_dec_t                       dec;
    port_cfg_t                      cfg;
    logic [N_PORTS-1:0][PORT_W-1:0] lat_q;

    ppc_bus_decode u_dec (
        .cs    (cs),
        .rd    (rd),
        .wr    (wr),
        .addr  (addr),
        .wdata (wdata),
        .dec   (dec)
    );

    ppc_cfg_reg u_cfg (
        .clk    (clk),
        .rst    (rst),
        .wr_cfg (dec.wr_cfg),
        .wdata  (wdata),
        .cfg    (cfg)
    );

    for (genvar gi = 0; gi < N_PORTS; gi++) begin : g_lat
        localparam bit HAS_BIT_CMD = (gi == N_PORTS - 1);
        ppc_out_latch #(.W(PORT_W), .IW(IDX_W)) u_lat (
            .clk      (clk),
            .rst      (rst),
            .clr      (dec.wr_cfg),
            .load     (dec.wr_port[gi]),
            .load_val (wdata),
            .bit_we   (HAS_BIT_CMD ? dec.wr_bit : 1'b0),
            .bit_idx  (wdata[IDX_W:1]),
            .bit_val  (wdata[0]),
            .q        (lat_q[gi])
        );
    end

    ppc_rd_mux u_rd (
        .dec   (dec),
        .cfg   (cfg),
        .lat   (lat_q),
        .pa_in (pa_in),
        .pb_in (pb_in),
        .pc_in (pc_in),
        .rdata (rdata)
    );

    assign pa_out   = lat_q[0];
    assign pb_out   = lat_q[1];
    assign pc_out   = lat_q[2];
    assign pa_oe    = !cfg.a_is_in;
    assign pb_oe    = !cfg.b_is_in;
    assign pc_oe_hi = !cfg.cu_is_in;
    assign pc_oe_lo = !cfg.cl_is_in;

    // R3: no state moves without a selected write
    p_no_write_r3: assert property (@(posedge clk) disable iff (rst)
        !(cs && wr) |=> $stable({pa_out, pb_out, pc_out, pa_oe, pb_oe, pc_oe_hi, pc_oe_lo}))
        else $error("state changed without a selected write");

    // R4: direction bits of a configuration word reach the enables
    p_dir_r4: assert property (@(posedge clk) disable iff (rst)
        (cs && wr && addr == 2'b11 && wdata[7]) |=>
            (pa_oe == !$past(wdata[4]) && pc_oe_hi == !$past(wdata[3]) &&
             pb_oe == !$past(wdata[1]) && pc_oe_lo == !$past(wdata[0])))
        else $error("configuration word directions wrong");

    // R5: configuration word empties all latches
    p_cfg_clear_r5: assert property (@(posedge clk) disable iff (rst)
        (cs && wr && addr == 2'b11 && wdata[7]) |=>
            (pa_out == 8'h00 && pb_out == 8'h00 && pc_out == 8'h00))
        else $error("configuration word left latch data");

    // R6: a bit command hits its bit and keeps directions
    p_bit_cmd_r6: assert property (@(posedge clk) disable iff (rst)
        (cs && wr && addr == 2'b11 && !wdata[7]) |=>
            (pc_out[$past(wdata[3:1])] == $past(wdata[0]) &&
             $stable({pa_oe, pb_oe, pc_oe_hi, pc_oe_lo})))
        else $error("bit command wrong");

    // R8: read bus quiet unless a selected read
    p_rd_idle_r8: assert property (@(posedge clk) disable iff (rst)
        !(cs && rd) |-> rdata == 8'h00)
        else $error("rdata driven without a selected read");

    // R8: control address reads as zero
    p_ctrl_read_r8: assert property (@(posedge clk) disable iff (rst)
        (cs && rd && addr == 2'b11) |-> rdata == 8'h00)
        else $error("control address read non-zero");
endmodule

// File: tb/pio_port_ctrl_tb.sv
module pio_port_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cs = 0, rd = 0, wr = 0;
    logic [1:0] addr = 0;
    logic [7:0] wdata = 0, pa_in = 0, pb_in = 0, pc_in = 0;
    logic [7:0] rdata, pa_out, pb_out, pc_out;
    logic       pa_oe, pb_oe, pc_oe_hi, pc_oe_lo;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    string phase = "R1";

    // behavioural reference state
    int m_lat [3];
    bit m_a_in, m_b_in, m_cu_in, m_cl_in;

    always #5 clk = ~clk;

    pio_port_ctrl u_dut (
        .clk(clk), .rst(rst), .cs(cs), .rd(rd), .wr(wr), .addr(addr),
        .wdata(wdata), .rdata(rdata),
        .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
        .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
        .pc_in(pc_in), .pc_out(pc_out), .pc_oe_hi(pc_oe_hi), .pc_oe_lo(pc_oe_lo)
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
        end
    endtask

    function automatic int model_read();
        int v;
        if (!(cs && rd)) return 0;
        case (addr)
            2'd0: v = m_a_in ? int'(pa_in) : m_lat[0];
            2'd1: v = m_b_in ? int'(pb_in) : m_lat[1];
            2'd2: v = ((m_cu_in ? int'(pc_in) : m_lat[2]) & 'hF0) |
                      ((m_cl_in ? int'(pc_in) : m_lat[2]) & 'h0F);
            default: v = 0;
        endcase
        return v;
    endfunction

    task automatic step();
        @(posedge clk);
        if (rst) begin
            m_lat = '{0, 0, 0};
            {m_a_in, m_b_in, m_cu_in, m_cl_in} = 4'b1111;
        end else if (cs && wr) begin
            if (addr != 2'd3) m_lat[addr] = int'(wdata);
            else if (wdata[7]) begin
                m_lat = '{0, 0, 0};
                m_a_in = wdata[4]; m_cu_in = wdata[3];
                m_b_in = wdata[1]; m_cl_in = wdata[0];
            end else begin
                if (wdata[0]) m_lat[2] = m_lat[2] | (1 << wdata[3:1]);
                else          m_lat[2] = m_lat[2] & ~(1 << wdata[3:1]);
            end
        end
        @(negedge clk);
        check(phase, "pa_out", pa_out, m_lat[0]);
        check(phase, "pb_out", pb_out, m_lat[1]);
        check(phase, "pc_out", pc_out, m_lat[2]);
        check(phase, "oe", {pa_oe, pb_oe, pc_oe_hi, pc_oe_lo},
              {!m_a_in, !m_b_in, !m_cu_in, !m_cl_in});
        check(phase, "rdata", rdata, model_read());
    endtask

    task automatic bus(input string tag, input bit c, input bit r, input bit w,
                       input logic [1:0] a, input logic [7:0] d);
        phase = tag;
        cs = c; rd = r; wr = w; addr = a; wdata = d;
        step();
    endtask

    initial begin
        repeat (2) step();
        @(negedge clk);
        rst = 1'b0;
        pa_in = 8'h3C; pb_in = 8'hC3; pc_in = 8'h96;
        // R1: reset state, read of input port A shows pins
        bus("R1", 1, 1, 0, 2'd0, 8'h00);
        check("R1", "pa_oe after reset", pa_oe, 0);
        check("R7", "input port read", rdata, 8'h3C);
        // R2: latch written while input; pins still read back
        bus("R2", 1, 0, 1, 2'd0, 8'h5A);
        check("R2", "latch while input", pa_out, 8'h5A);
        bus("R7", 1, 1, 0, 2'd0, 8'h00);
        // R4/R5: all outputs, latches cleared
        bus("R4", 1, 0, 1, 2'd3, 8'h80);
        check("R5", "clear on config", pa_out, 8'h00);
        check("R4", "all enables", {pa_oe, pb_oe, pc_oe_hi, pc_oe_lo}, 4'hF);
        bus("R2", 1, 0, 1, 2'd0, 8'hA5);
        bus("R2", 1, 0, 1, 2'd1, 8'h11);
        bus("R2", 1, 0, 1, 2'd2, 8'h00);
        bus("R7", 1, 1, 0, 2'd1, 8'h00);
        check("R7", "output port read", rdata, 8'h11);
        // R3: write without select
        bus("R3", 0, 0, 1, 2'd0, 8'hFF);
        bus("R3", 0, 0, 1, 2'd3, 8'h9B);
        check("R3", "latch kept", pa_out, 8'hA5);
        // R6: bit commands
        bus("R6", 1, 0, 1, 2'd3, 8'h0F);
        check("R6", "set bit 7", pc_out, 8'h80);
        bus("R6", 1, 0, 1, 2'd3, 8'h01);
        check("R6", "set bit 0", pc_out, 8'h81);
        bus("R6", 1, 0, 1, 2'd3, 8'h0B);
        bus("R6", 1, 0, 1, 2'd3, 8'h04);
        check("R6", "clear low bit 2", pc_out, 8'hA1);
        bus("R6", 1, 0, 1, 2'd3, 8'h00);
        check("R6", "clear bit 0", pc_out, 8'hA0);
        // R9: mode bits set; A in, C upper out, B out, C lower in
        bus("R9", 1, 0, 1, 2'd3, 8'hF5);
        check("R9", "enables with mode bits", {pa_oe, pb_oe, pc_oe_hi, pc_oe_lo}, 4'b0110);
        bus("R7", 1, 0, 1, 2'd2, 8'h7E);
        bus("R7", 1, 1, 0, 2'd2, 8'h00);
        check("R7", "port C split read", rdata, 8'h76);
        // R8: control read and idle bus
        bus("R8", 1, 1, 0, 2'd3, 8'h00);
        check("R8", "control read", rdata, 0);
        bus("R8", 0, 1, 0, 2'd2, 8'h00);
        check("R8", "no select read", rdata, 0);
        // mixed traffic against the model
        for (int i = 0; i < 300; i++) begin
            pa_in = 8'($urandom); pb_in = 8'($urandom); pc_in = 8'($urandom);
            bus("R7", 1'($urandom), 1'($urandom), 1'($urandom), 2'($urandom), 8'($urandom));
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule